// File: doc/BRIEF.md
# Radio Bring-Up Command Sequencer

This block takes a packet radio that answers on a clear-to-send style serial command channel from hard shutdown to the point where it is transmitting. A command engine elsewhere handles the serial bit timing. This block produces, one command at a time, the byte frame the engine must send and the number of response bytes it must read back. It also drives the radio's active-high shutdown pin.

A single start pulse runs the whole bring-up. First the shutdown pin is held high for a fixed number of clocks and then released. The part identifier is then polled until the expected value comes back. After that the block walks a fixed command list:

- power-up
- interrupt clear
- interrupt disable
- pin configuration
- band, divider, deviation and output-power property writes
- filter coefficient write
- start-transmit

Every configuration byte comes from an input port and is sampled while the matching frame is presented. Any error reported by the engine stops the sequence, returns the radio to shutdown and raises a fault flag.

Top module: `radio_bringup_seq`

## Requirements

Conventions used below:
- Frame byte k sits on `cmd_frame_o[8k+7:8k]` and byte 0 is sent first. Byte positions not used by a command read zero.
- Opcode and property defaults (all parameters):

| Parameter | Default |
|---|---|
| OP_PART | 0x01 |
| OP_PWRUP | 0x02 |
| OP_SETP | 0x11 |
| OP_GPIO | 0x13 |
| OP_ICLR | 0x20 |
| OP_TX | 0x31 |
| BOOT_FN | 0x01 |
| GRP_INT | 0x01 |
| IEN_IDX | 0x00 |
| GRP_MOD | 0x20 |
| BAND_IDX | 0x51 |
| DEV_IDX | 0x0A |
| COEF8_IDX | 0x0F |
| GRP_FRQ | 0x40 |
| DIV_IDX | 0x00 |
| GRP_PA | 0x22 |
| PWR_IDX | 0x01 |
| IRQ_NOP | 0x00 |
| SDO_NOP | 0x00 |

- R1: Out of reset:
  - `sdn_o` is 1.
  - `busy_o`, `fault_o` and `cmd_req_o` are 0.
- R2: Start timing, when `start_i` is sampled high while idle:
  - `sdn_o` is high for exactly SDN_CYC cycles, counting from the cycle after that start edge, and then goes low.
  - The first request appears GAP_CYC cycles after the release.
  - `sdn_o` stays low after a successful sequence.
- R3: Part-identifier poll:
  - The frame is the single byte OP_PART, with `cmd_rx_len_o` = 3.
  - `cmd_id_i` carries response byte 1 in bits 15:8 and byte 2 in bits 7:0.
  - Unless `cmd_id_i` equals PART_ID (default 16'h4468), the poll is reissued after GAP_CYC idle cycles. A byte-swapped value does not match.
- R4: The power-up frame is 7 bytes long, in this order:
  - OP_PWRUP
  - BOOT_FN
  - `clk_src_i`
  - `xo_freq_i`, most significant byte first
- R5: The interrupt-clear frame is 4 bytes long, in this order:
  - OP_ICLR
  - `ph_clr_i & 8'h22`
  - 0x00
  - `chip_clr_i`
- R6: The command directly after interrupt clear is a property write of value 0x00 to group GRP_INT, index IEN_IDX.
- R7: The pin-configuration frame is 8 bytes long, in this order:
  - OP_GPIO
  - the four pin-mode bytes, where `gpio_mode_i[8k+7:8k]` is the mode of pin k
  - IRQ_NOP
  - SDO_NOP
  - `drive_i`
- R8: Property-write frames:
  - Layout: OP_SETP, group, count N, start index, then N value bytes, most significant first. `cmd_tx_len_o` is 4+N.
  - The writes, in order:
    - band: `band_i` (N=1)
    - divider: `{int_div_i, frac_i}` (N=4)
    - deviation: `dev_i` (N=3)
    - output power: `pwr_i` (N=1)
- R9: The coefficient write has N=9 and start index COEF8_IDX. `coef_i[8k+7:8k]` holds coefficient k, and the values are sent from coefficient 8 down to coefficient 0.
- R10: The last command is 5 bytes long: OP_TX, `chan_i`, 0x10, 0x00, 0x00.
- R11: Request handshake:
  - `cmd_req_o` is a one-cycle pulse.
  - No request is raised while a command is outstanding.
  - After a `cmd_done_i` that needs no retry, the next request follows in the very next cycle.
  - All commands other than the poll have `cmd_rx_len_o` = 0.
- R12: Busy flag and restarts:
  - `busy_o` rises in the cycle after the start edge.
  - It falls in the cycle after the final `cmd_done_i`.
  - `start_i` has no effect while busy.
- R13: Error abort:
  - A `cmd_done_i` with `cmd_err_i` set raises `fault_o`, clears `busy_o` and drives `sdn_o` high.
  - No further request is raised.
  - The next start clears `fault_o`.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin bring-up (accepted when idle) |
| xo_freq_i | input | 32 | Reference frequency for the power-up frame |
| clk_src_i | input | 8 | Clock-source selector byte |
| ph_clr_i | input | 8 | Packet-handler interrupt-clear mask |
| chip_clr_i | input | 8 | Chip interrupt-clear mask |
| gpio_mode_i | input | 32 | Four pin-mode bytes, pin k in byte k |
| drive_i | input | 8 | Pin drive-strength byte |
| band_i | input | 8 | Band / output-divider property value |
| int_div_i | input | 8 | Synthesizer integer divider |
| frac_i | input | 24 | Synthesizer fractional divider |
| dev_i | input | 24 | Frequency deviation value |
| pwr_i | input | 8 | Output power level |
| coef_i | input | 72 | Nine filter coefficients, coefficient k in byte k |
| chan_i | input | 8 | Transmit channel |
| cmd_req_o | output | 1 | One-cycle command request |
| cmd_frame_o | output | 104 | Command bytes, byte k at bits 8k+7:8k |
| cmd_tx_len_o | output | 4 | Number of bytes to send |
| cmd_rx_len_o | output | 2 | Number of response bytes to read |
| cmd_done_i | input | 1 | Command engine finished the current command |
| cmd_err_i | input | 1 | Engine error, valid with cmd_done_i |
| cmd_id_i | input | 16 | Response bytes 1 (15:8) and 2 (7:0) of the poll |
| sdn_o | output | 1 | Radio shutdown, active high |
| busy_o | output | 1 | Sequence in progress |
| fault_o | output | 1 | Sequence aborted by an engine error |

## Verification

The hardest situations to reach from the ports are these:
- Several failed identity polls followed by a clean pass, including one failure where the two identifier bytes arrive swapped.
- An error arriving in the middle of the property writes, after many frames have already been accepted.

The bench plays the command engine. It answers polls from a scripted list of identifiers and injects an error on a chosen command index, so each run steers the sequencer to a specific depth before aborting. A stray start pulse is applied while a command is outstanding, and a further run follows a fault to show that the flag clears.

// File: rtl/radio_bringup_pkg.sv
package radio_bringup_pkg;
  localparam int COEF_N    = 9;
  localparam int HDR_N     = 4;
  localparam int FRAME_MAX = HDR_N + COEF_N;
  localparam int RSP_LEN   = 3;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);
  localparam int RX_W      = $clog2(RSP_LEN + 1);
  localparam int VAL_W     = $clog2(COEF_N + 1);

  typedef enum logic [3:0] {
    ST_PART, ST_PWRUP, ST_ICLR, ST_IEN, ST_GPIO, ST_BAND,
    ST_DIV, ST_DEV, ST_PWR, ST_COEF, ST_TX
  } step_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SDN, PH_GAP, PH_ISSUE, PH_WAIT
  } phase_e;

  typedef logic [FRAME_MAX-1:0][7:0] frame_t;
  typedef logic [COEF_N-1:0][7:0]    pval_t;
endpackage

// File: rtl/radio_bringup_delay.sv
module radio_bringup_delay #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/radio_bringup_prop_pack.sv
module radio_bringup_prop_pack
  import radio_bringup_pkg::*;
#(
  parameter logic [7:0] OP_SETP = 8'h11
) (
  input  logic [7:0]       grp_i,
  input  logic [7:0]       prop_i,
  input  logic [VAL_W-1:0] n_i,
  input  pval_t            val_i,   // byte 0 = least significant
  output frame_t           frame_o
);
  pval_t pay;

  // slot j carries value byte n-1-j: most significant first
  for (genvar j = 0; j < COEF_N; j++) begin : g_slot
    logic [VAL_W-1:0] src;
    assign src    = n_i - VAL_W'(j + 1);
    assign pay[j] = (VAL_W'(j) < n_i) ? val_i[src] : 8'h00;
  end

  always_comb begin
    frame_o    = '0;
    frame_o[0] = OP_SETP;
    frame_o[1] = grp_i;
    frame_o[2] = 8'(n_i);
    frame_o[3] = prop_i;
    for (int j = 0; j < COEF_N; j++) frame_o[HDR_N + j] = pay[j];
  end
endmodule

// File: rtl/radio_bringup_frame.sv
module radio_bringup_frame
  import radio_bringup_pkg::*;
#(
  parameter logic [7:0] OP_PART   = 8'h01,
  parameter logic [7:0] OP_PWRUP  = 8'h02,
  parameter logic [7:0] OP_SETP   = 8'h11,
  parameter logic [7:0] OP_GPIO   = 8'h13,
  parameter logic [7:0] OP_ICLR   = 8'h20,
  parameter logic [7:0] OP_TX     = 8'h31,
  parameter logic [7:0] BOOT_FN   = 8'h01,
  parameter logic [7:0] IRQ_NOP   = 8'h00,
  parameter logic [7:0] SDO_NOP   = 8'h00,
  parameter logic [7:0] GRP_INT   = 8'h01,
  parameter logic [7:0] IEN_IDX   = 8'h00,
  parameter logic [7:0] GRP_MOD   = 8'h20,
  parameter logic [7:0] BAND_IDX  = 8'h51,
  parameter logic [7:0] DEV_IDX   = 8'h0A,
  parameter logic [7:0] COEF8_IDX = 8'h0F,
  parameter logic [7:0] GRP_FRQ   = 8'h40,
  parameter logic [7:0] DIV_IDX   = 8'h00,
  parameter logic [7:0] GRP_PA    = 8'h22,
  parameter logic [7:0] PWR_IDX   = 8'h01
) (
  input  step_e             step_i,
  input  logic [31:0]       xo_freq_i,
  input  logic [7:0]        clk_src_i,
  input  logic [7:0]        ph_clr_i,
  input  logic [7:0]        chip_clr_i,
  input  logic [31:0]       gpio_mode_i,
  input  logic [7:0]        drive_i,
  input  logic [7:0]        band_i,
  input  logic [7:0]        int_div_i,
  input  logic [23:0]       frac_i,
  input  logic [23:0]       dev_i,
  input  logic [7:0]        pwr_i,
  input  pval_t             coef_i,
  input  logic [7:0]        chan_i,
  output frame_t            frame_o,
  output logic [LEN_W-1:0]  tx_len_o,
  output logic [RX_W-1:0]   rx_len_o
);
  logic [7:0]       p_grp, p_prop;
  logic [VAL_W-1:0] p_n;
  pval_t            p_val;
  frame_t           p_frame;

  always_comb begin
    p_grp  = GRP_MOD;
    p_prop = 8'h00;
    p_n    = VAL_W'(1);
    p_val  = '0;
    unique case (step_i)
      ST_IEN:  begin p_grp = GRP_INT; p_prop = IEN_IDX; end
      ST_BAND: begin p_prop = BAND_IDX; p_val[0] = band_i; end
      ST_DIV:  begin
        p_grp = GRP_FRQ; p_prop = DIV_IDX; p_n = VAL_W'(4);
        p_val[3:0] = {int_div_i, frac_i};
      end
      ST_DEV:  begin p_prop = DEV_IDX; p_n = VAL_W'(3); p_val[2:0] = dev_i; end
      ST_PWR:  begin p_grp = GRP_PA; p_prop = PWR_IDX; p_val[0] = pwr_i; end
      ST_COEF: begin p_prop = COEF8_IDX; p_n = VAL_W'(COEF_N); p_val = coef_i; end
      default: ;
    endcase
  end

  radio_bringup_prop_pack #(.OP_SETP(OP_SETP)) u_pack (
    .grp_i  (p_grp),
    .prop_i (p_prop),
    .n_i    (p_n),
    .val_i  (p_val),
    .frame_o(p_frame)
  );

  always_comb begin
    frame_o  = '0;
    rx_len_o = '0;
    tx_len_o = LEN_W'(HDR_N) + LEN_W'(p_n);
    unique case (step_i)
      ST_PART: begin
        frame_o[0] = OP_PART;
        tx_len_o   = LEN_W'(1);
        rx_len_o   = RX_W'(RSP_LEN);
      end
      ST_PWRUP: begin
        frame_o[0] = OP_PWRUP;  frame_o[1] = BOOT_FN;  frame_o[2] = clk_src_i;
        frame_o[3] = xo_freq_i[31:24]; frame_o[4] = xo_freq_i[23:16];
        frame_o[5] = xo_freq_i[15:8];  frame_o[6] = xo_freq_i[7:0];
        tx_len_o   = LEN_W'(7);
      end
      ST_ICLR: begin
        frame_o[0] = OP_ICLR;
        frame_o[1] = ph_clr_i & 8'h22;
        frame_o[3] = chip_clr_i;
        tx_len_o   = LEN_W'(4);
      end
      ST_GPIO: begin
        frame_o[0] = OP_GPIO;
        for (int k = 0; k < 4; k++) frame_o[1 + k] = gpio_mode_i[8*k +: 8];
        frame_o[5] = IRQ_NOP; frame_o[6] = SDO_NOP; frame_o[7] = drive_i;
        tx_len_o   = LEN_W'(8);
      end
      ST_TX: begin
        frame_o[0] = OP_TX; frame_o[1] = chan_i; frame_o[2] = 8'h10;
        tx_len_o   = LEN_W'(5);
      end
      default: frame_o = p_frame;
    endcase
  end
endmodule

// File: rtl/radio_bringup_seq.sv
module radio_bringup_seq
  import radio_bringup_pkg::*;
#(
  parameter int          SDN_CYC   = 20,
  parameter int          GAP_CYC   = 5,
  parameter logic [15:0] PART_ID   = 16'h4468,
  parameter logic [7:0]  OP_PART   = 8'h01,
  parameter logic [7:0]  OP_PWRUP  = 8'h02,
  parameter logic [7:0]  OP_SETP   = 8'h11,
  parameter logic [7:0]  OP_GPIO   = 8'h13,
  parameter logic [7:0]  OP_ICLR   = 8'h20,
  parameter logic [7:0]  OP_TX     = 8'h31,
  parameter logic [7:0]  BOOT_FN   = 8'h01,
  parameter logic [7:0]  IRQ_NOP   = 8'h00,
  parameter logic [7:0]  SDO_NOP   = 8'h00,
  parameter logic [7:0]  GRP_INT   = 8'h01,
  parameter logic [7:0]  IEN_IDX   = 8'h00,
  parameter logic [7:0]  GRP_MOD   = 8'h20,
  parameter logic [7:0]  BAND_IDX  = 8'h51,
  parameter logic [7:0]  DEV_IDX   = 8'h0A,
  parameter logic [7:0]  COEF8_IDX = 8'h0F,
  parameter logic [7:0]  GRP_FRQ   = 8'h40,
  parameter logic [7:0]  DIV_IDX   = 8'h00,
  parameter logic [7:0]  GRP_PA    = 8'h22,
  parameter logic [7:0]  PWR_IDX   = 8'h01
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [31:0]            xo_freq_i,
  input  logic [7:0]             clk_src_i,
  input  logic [7:0]             ph_clr_i,
  input  logic [7:0]             chip_clr_i,
  input  logic [31:0]            gpio_mode_i,
  input  logic [7:0]             drive_i,
  input  logic [7:0]             band_i,
  input  logic [7:0]             int_div_i,
  input  logic [23:0]            frac_i,
  input  logic [23:0]            dev_i,
  input  logic [7:0]             pwr_i,
  input  logic [COEF_N*8-1:0]    coef_i,
  input  logic [7:0]             chan_i,
  output logic                   cmd_req_o,
  output logic [FRAME_MAX*8-1:0] cmd_frame_o,
  output logic [LEN_W-1:0]       cmd_tx_len_o,
  output logic [RX_W-1:0]        cmd_rx_len_o,
  input  logic                   cmd_done_i,
  input  logic                   cmd_err_i,
  input  logic [15:0]            cmd_id_i,
  output logic                   sdn_o,
  output logic                   busy_o,
  output logic                   fault_o
);
  localparam int TMAX = (SDN_CYC > GAP_CYC) ? SDN_CYC : GAP_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  phase_e        ph_q;
  step_e         step_q;
  logic          sdn_q, busy_q, fault_q;
  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          id_ok, retry;
  frame_t        frame;

  assign id_ok = (cmd_id_i == PART_ID);
  assign retry = (step_q == ST_PART) && !id_ok;

  always_comb begin
    t_load = 1'b0;
    t_val  = TW'(GAP_CYC - 1);
    unique case (ph_q)
      PH_IDLE: if (start_i) begin t_load = 1'b1; t_val = TW'(SDN_CYC - 1); end
      PH_SDN:  t_load = t_zero;
      PH_WAIT: t_load = cmd_done_i && !cmd_err_i && retry;
      default: ;
    endcase
  end

  radio_bringup_delay #(.W(TW)) u_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(t_load),
    .val_i (t_val),
    .zero_o(t_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      step_q  <= ST_PART;
      sdn_q   <= 1'b1;
      busy_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q    <= PH_SDN;
          step_q  <= ST_PART;
          sdn_q   <= 1'b1;
          busy_q  <= 1'b1;
          fault_q <= 1'b0;
        end
        PH_SDN: if (t_zero) begin
          sdn_q <= 1'b0;
          ph_q  <= PH_GAP;
        end
        PH_GAP:   if (t_zero) ph_q <= PH_ISSUE;
        PH_ISSUE: ph_q <= PH_WAIT;
        PH_WAIT: if (cmd_done_i) begin
          if (cmd_err_i) begin
            fault_q <= 1'b1;
            busy_q  <= 1'b0;
            sdn_q   <= 1'b1;
            ph_q    <= PH_IDLE;
          end else if (retry) begin
            ph_q <= PH_GAP;
          end else if (step_q == ST_TX) begin
            busy_q <= 1'b0;
            ph_q   <= PH_IDLE;
          end else begin
            step_q <= step_e'(step_q + 4'd1);
            ph_q   <= PH_ISSUE;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  radio_bringup_frame #(
    .OP_PART(OP_PART), .OP_PWRUP(OP_PWRUP), .OP_SETP(OP_SETP), .OP_GPIO(OP_GPIO),
    .OP_ICLR(OP_ICLR), .OP_TX(OP_TX), .BOOT_FN(BOOT_FN), .IRQ_NOP(IRQ_NOP),
    .SDO_NOP(SDO_NOP), .GRP_INT(GRP_INT), .IEN_IDX(IEN_IDX), .GRP_MOD(GRP_MOD),
    .BAND_IDX(BAND_IDX), .DEV_IDX(DEV_IDX), .COEF8_IDX(COEF8_IDX),
    .GRP_FRQ(GRP_FRQ), .DIV_IDX(DIV_IDX), .GRP_PA(GRP_PA), .PWR_IDX(PWR_IDX)
  ) u_frame (
    .step_i     (step_q),
    .xo_freq_i  (xo_freq_i),
    .clk_src_i  (clk_src_i),
    .ph_clr_i   (ph_clr_i),
    .chip_clr_i (chip_clr_i),
    .gpio_mode_i(gpio_mode_i),
    .drive_i    (drive_i),
    .band_i     (band_i),
    .int_div_i  (int_div_i),
    .frac_i     (frac_i),
    .dev_i      (dev_i),
    .pwr_i      (pwr_i),
    .coef_i     (coef_i),
    .chan_i     (chan_i),
    .frame_o    (frame),
    .tx_len_o   (cmd_tx_len_o),
    .rx_len_o   (cmd_rx_len_o)
  );

  assign cmd_frame_o = frame;
  assign cmd_req_o   = (ph_q == PH_ISSUE);
  assign sdn_o       = sdn_q;
  assign busy_o      = busy_q;
  assign fault_o     = fault_q;
endmodule

// File: rtl/radio_bringup_chk.sv
module radio_bringup_chk
  import radio_bringup_pkg::*;
#(
  parameter logic [7:0] OP_PART = 8'h01,
  parameter logic [7:0] OP_SETP = 8'h11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_req_o,
  input logic [7:0]       op_i,
  input logic [7:0]       cnt_i,
  input logic [LEN_W-1:0] cmd_tx_len_o,
  input logic [RX_W-1:0]  cmd_rx_len_o,
  input logic             cmd_done_i,
  input logic             sdn_o,
  input logic             busy_o,
  input logic             fault_o
);
  p_req_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o |=> !cmd_req_o);

  p_quiet_in_sdn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdn_o |-> !cmd_req_o);

  p_req_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o |-> busy_o);

  p_busy_end_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(cmd_done_i));

  p_fault_safe_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !busy_o) |-> sdn_o);

  p_setprop_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && op_i == OP_SETP) |-> (int'(cmd_tx_len_o) == 4 + int'(cnt_i)));

  p_poll_rx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && op_i == OP_PART) |-> (int'(cmd_rx_len_o) == RSP_LEN));

  p_other_rx_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && op_i != OP_PART) |-> (cmd_rx_len_o == '0));

  p_sdn_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdn_o) |-> busy_o);
endmodule

bind radio_bringup_seq radio_bringup_chk #(
  .OP_PART(OP_PART),
  .OP_SETP(OP_SETP)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_req_o   (cmd_req_o),
  .op_i        (cmd_frame_o[7:0]),
  .cnt_i       (cmd_frame_o[23:16]),
  .cmd_tx_len_o(cmd_tx_len_o),
  .cmd_rx_len_o(cmd_rx_len_o),
  .cmd_done_i  (cmd_done_i),
  .sdn_o       (sdn_o),
  .busy_o      (busy_o),
  .fault_o     (fault_o)
);

// File: tb/sim_radio_bringup_seq.sv
`timescale 1ns/1ps
module sim_radio_bringup_seq;
  import radio_bringup_pkg::*;

  localparam int          SDN_CYC = 20;
  localparam int          GAP_CYC = 5;
  localparam int          LAT     = 3;
  localparam logic [15:0] PART_ID = 16'h4468;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                   start_i = 1'b0;
  logic [31:0]            xo, gpio;
  logic [7:0]             clk_src, ph, chip, drive, band, idiv, pwr, chan;
  logic [23:0]            frac, dev;
  logic [COEF_N*8-1:0]    coef;
  logic                   cmd_req, cmd_done = 1'b0, cmd_err = 1'b0;
  logic [FRAME_MAX*8-1:0] frame;
  logic [LEN_W-1:0]       tx_len;
  logic [RX_W-1:0]        rx_len;
  logic [15:0]            cmd_id = 16'h0000;
  logic                   sdn, busy, fault;

  int n_chk = 0, n_fail = 0;

  radio_bringup_seq #(.SDN_CYC(SDN_CYC), .GAP_CYC(GAP_CYC), .PART_ID(PART_ID)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
    .xo_freq_i(xo), .clk_src_i(clk_src), .ph_clr_i(ph), .chip_clr_i(chip),
    .gpio_mode_i(gpio), .drive_i(drive), .band_i(band), .int_div_i(idiv),
    .frac_i(frac), .dev_i(dev), .pwr_i(pwr), .coef_i(coef), .chan_i(chan),
    .cmd_req_o(cmd_req), .cmd_frame_o(frame), .cmd_tx_len_o(tx_len),
    .cmd_rx_len_o(rx_len), .cmd_done_i(cmd_done), .cmd_err_i(cmd_err),
    .cmd_id_i(cmd_id), .sdn_o(sdn), .busy_o(busy), .fault_o(fault)
  );

  string tags[11] = '{"R3","R4","R5","R6","R7","R8","R8","R8","R8","R9","R10"};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected command bytes, built from the requirement text
  task automatic exp_cmd(input int s, output logic [127:0] f, output int len, output int rx);
    byte unsigned q[$];
    q = {};
    case (s)
      0:  q = {8'h01};
      1:  q = {8'h02, 8'h01, clk_src, xo[31:24], xo[23:16], xo[15:8], xo[7:0]};
      2:  q = {8'h20, ph & 8'h22, 8'h00, chip};
      3:  q = {8'h11, 8'h01, 8'h01, 8'h00, 8'h00};
      4:  q = {8'h13, gpio[7:0], gpio[15:8], gpio[23:16], gpio[31:24], 8'h00, 8'h00, drive};
      5:  q = {8'h11, 8'h20, 8'h01, 8'h51, band};
      6:  q = {8'h11, 8'h40, 8'h04, 8'h00, idiv, frac[23:16], frac[15:8], frac[7:0]};
      7:  q = {8'h11, 8'h20, 8'h03, 8'h0A, dev[23:16], dev[15:8], dev[7:0]};
      8:  q = {8'h11, 8'h22, 8'h01, 8'h01, pwr};
      9:  begin
        q = {8'h11, 8'h20, 8'h09, 8'h0F};
        for (int k = 8; k >= 0; k--) q.push_back(coef[8*k +: 8]);
      end
      default: q = {8'h31, chan, 8'h10, 8'h00, 8'h00};
    endcase
    f = '0;
    foreach (q[k]) f[8*k +: 8] = q[k];
    len = q.size();
    rx  = (s == 0) ? 3 : 0;
  endtask

  task automatic set_cfg(input int which);
    if (which == 0) begin
      xo = 32'h01C9_C380; clk_src = 8'h01; ph = 8'hFF; chip = 8'hA5;
      gpio = 32'h4101_4101; drive = 8'h60; band = 8'h0A; idiv = 8'h3C;
      frac = 24'h0A_BCDE; dev = 24'h01_2345; pwr = 8'h7F; chan = 8'h00;
      for (int k = 0; k < COEF_N; k++) coef[8*k +: 8] = 8'(16*k + 3);
    end else begin
      xo = 32'hDEAD_BEEF; clk_src = 8'h00; ph = 8'hDD; chip = 8'h3C;
      gpio = 32'h0302_0100; drive = 8'h20; band = 8'h0D; idiv = 8'h41;
      frac = 24'hF0_0F55; dev = 24'h00_00C7; pwr = 8'h10; chan = 8'h2B;
      for (int k = 0; k < COEF_N; k++) coef[8*k +: 8] = 8'(8'hF2 - 8'(7*k));
    end
  endtask

  task automatic run_seq(input int bad_polls, input int err_step, input bit poke);
    int cnt, s, polls, el, er;
    logic [127:0] ef;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(busy === 1'b1, "R12", "busy after start", busy, 1);
    check(fault === 1'b0, "R13", "fault cleared by start", fault, 0);
    cnt = 0;
    while (sdn === 1'b1 && cnt < 1000) begin cnt++; @(negedge clk); end
    check(cnt == SDN_CYC, "R2", "shutdown pulse cycles", cnt, SDN_CYC);
    cnt = 0;
    while (cmd_req !== 1'b1 && cnt < 1000) begin cnt++; @(negedge clk); end
    check(cnt == GAP_CYC, "R2", "release to first request", cnt, GAP_CYC);
    s = 0; polls = bad_polls;
    forever begin
      exp_cmd(s, ef, el, er);
      check({24'b0, frame} === ef, tags[s], "frame bytes", {24'b0, frame}, ef);
      check(int'(tx_len) == el, tags[s], "send length", tx_len, el);
      check(int'(rx_len) == er, (s == 0) ? "R3" : "R11", "read length", rx_len, er);
      for (int w = 0; w < LAT; w++) begin
        start_i = (poke && s == 5 && w == 0);
        @(negedge clk);
        check(cmd_req === 1'b0 && busy === 1'b1, "R11", "outstanding quiet",
              {cmd_req, busy}, 2'b01);
      end
      start_i  = 1'b0;
      cmd_done = 1'b1;
      cmd_err  = (s == err_step);
      cmd_id   = (s == 0 && polls > 0) ? ((polls % 2 == 1) ? 16'h6844 : 16'h0044) : PART_ID;
      @(negedge clk);
      cmd_done = 1'b0; cmd_err = 1'b0;
      if (s == err_step) begin
        check({fault, busy, sdn} === 3'b101, "R13", "abort state", {fault, busy, sdn}, 3'b101);
        cnt = 0;
        repeat (30) begin @(negedge clk); if (cmd_req === 1'b1) cnt++; end
        check(cnt == 0, "R13", "no request after abort", cnt, 0);
        check(fault === 1'b1, "R13", "fault held", fault, 1);
        return;
      end
      if (s == 0 && polls > 0) begin
        polls--;
        cnt = 0;
        while (cmd_req !== 1'b1 && cnt < 1000) begin
          check(busy === 1'b1, "R12", "busy during retry", busy, 1);
          cnt++; @(negedge clk);
        end
        check(cnt == GAP_CYC, "R3", "poll retry gap", cnt, GAP_CYC);
      end else if (s == 10) begin
        check(busy === 1'b0, "R12", "busy after last done", busy, 0);
        check(fault === 1'b0, "R13", "no fault on success", fault, 0);
        check(sdn === 1'b0, "R2", "shutdown stays released", sdn, 0);
        return;
      end else begin
        check(cmd_req === 1'b1, "R11", "next request at once", cmd_req, 1);
        s++;
        if (poke && s == 6)
          check(sdn === 1'b0 && busy === 1'b1, "R12", "start ignored while busy",
                {sdn, busy}, 2'b01);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    set_cfg(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({sdn, busy, fault, cmd_req} === 4'b1000, "R1", "reset state",
          {sdn, busy, fault, cmd_req}, 4'b1000);
    run_seq(2, -1, 1'b1);    // two failed polls incl. swapped bytes, stray start
    set_cfg(1);
    run_seq(0, -1, 1'b0);    // restart from released shutdown, other data
    run_seq(1, 6, 1'b0);     // error on divider write
    set_cfg(0);
    run_seq(0, 0, 1'b0);     // error on first poll
    run_seq(3, -1, 1'b0);    // recovery after fault
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule